// File: doc/BRIEF.md
# 100BASE-X PCS Transmit Encoder

This block turns the nibbles a MAC presents on the media-independent transmit interface into a stream of 5-bit code groups, one per clock, ready for a serializer. While no frame is being sent it fills the line with Idle code groups. When a frame starts, the first two nibbles are replaced by the start-of-stream pair J then K. The remaining nibbles go through the 4B/5B table, and a nibble flagged as an error becomes the halt code group H. When the enable drops, the end-of-stream pair T then R is appended.

For copper links an 11-bit additive scrambler masks every encoded code group. For fiber links the scrambler output is left off. A separate symbol mode skips both the encoder and the scrambler and forwards the full 5-bit transmit data bus as the code group. Every result leaves a register two transmit clocks after its input was sampled.

Top module: `pcs_tx_encoder`

## Requirements
- R1: While `rst_n` is low, `sym_out` is 5'b11111 and the scrambler state is reloaded with its seed (default 11'h7FF).
- R2: A code group derived from the inputs sampled at a rising edge of `clk` appears on `sym_out` after the second following rising edge. It stays there for one clock.
- R3: When neither a frame nor its end delimiter is in progress, the code group is Idle, 5'b11111.
- R4: A rise of `tx_en` after Idle starts a frame. Its first sampled nibble is sent as J (5'b11000) and its second as K (5'b10001), whatever `txd` and `tx_er` hold.
- R5: From the third nibble of a frame on, `txd[3:0]` maps to 0:11110 1:01001 2:10100 3:10101 4:01010 5:01011 6:01110 7:01111 8:10010 9:10011 A:10110 B:10111 C:11010 D:11011 E:11100 F:11101. `txd[4]` has no effect outside symbol mode.
- R6: The first sample with `tx_en` low after a frame gives T (5'b01101), and the next gives R (5'b00111). The sample taken during R is discarded whatever `tx_en` is, and Idle or a new start follows.
- R7: A data nibble sampled with `tx_er` high is sent as H (5'b00100). `tx_er` has no effect on the J and K positions or while `tx_en` is low.
- R8: With `scramble_en` high and `symbol_mode` low, the code group is XORed with a 5-bit key. At each clock the 11-bit state s is stepped five times: fb = s[10]^s[8], s = {s[9:0], fb}. The first fb masks bit 4 and the fifth masks bit 0. With `scramble_en` low the encoded code group is sent unmasked.
- R9: With `symbol_mode` high, `txd[4:0]` is forwarded unchanged as the code group, with no encoding or scrambling.
- R10: The scrambler state never becomes zero. It advances five steps on every clock after reset in every mode, so the key sequence continues unbroken across mode changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Transmit clock, one code group per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_en | input | 1 | Frame enable from the MAC |
| tx_er | input | 1 | Transmit error flag from the MAC |
| txd | input | 5 | Transmit data; bits 3:0 are the nibble, bit 4 is used only in symbol mode |
| scramble_en | input | 1 | High for copper links (scrambled), low for fiber |
| symbol_mode | input | 1 | High to forward raw 5-bit code groups |
| sym_out | output | 5 | Registered code group to the serializer |

## Verification
The hardest case to reach is the scrambler key continuing correctly after a stretch of symbol mode. The key is invisible while bypassed, so it only shows once copper encoding resumes. The stimulus therefore runs frames with scrambling, switches to symbol mode with scrambling still requested, then returns to copper frames. At that point the reference must match with a key that advanced through every bypassed clock. The delimiter corner cases are also driven directly: one- and two-nibble frames, where T lands in the K slot or right after it, and error flags placed on the J and K positions and outside frames.

// File: rtl/pcs_tx_pkg.sv
package pcs_tx_pkg;

    localparam int SYM_W = 5;
    localparam int NIB_W = 4;

    typedef logic [SYM_W-1:0] sym_t;

    localparam sym_t SYM_IDLE = 5'b11111;
    localparam sym_t SYM_J    = 5'b11000;
    localparam sym_t SYM_K    = 5'b10001;
    localparam sym_t SYM_T    = 5'b01101;
    localparam sym_t SYM_R    = 5'b00111;
    localparam sym_t SYM_H    = 5'b00100;

    typedef enum logic [1:0] {
        FR_IDLE = 2'd0,
        FR_K    = 2'd1,
        FR_DATA = 2'd2,
        FR_R    = 2'd3
    } fr_state_e;

    // One sampled transmit beat with the mode bits that travel with it
    typedef struct packed {
        logic       en;
        logic       er;
        sym_t       d;
        logic       scr;
        logic       raw;
    } mii_beat_t;

    function automatic sym_t enc_4b5b(input logic [NIB_W-1:0] nib);
        sym_t c;
        case (nib)
            4'h0: c = 5'b11110;
            4'h1: c = 5'b01001;
            4'h2: c = 5'b10100;
            4'h3: c = 5'b10101;
            4'h4: c = 5'b01010;
            4'h5: c = 5'b01011;
            4'h6: c = 5'b01110;
            4'h7: c = 5'b01111;
            4'h8: c = 5'b10010;
            4'h9: c = 5'b10011;
            4'hA: c = 5'b10110;
            4'hB: c = 5'b10111;
            4'hC: c = 5'b11010;
            4'hD: c = 5'b11011;
            4'hE: c = 5'b11100;
            default: c = 5'b11101;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/pcs_tx_capture.sv
module pcs_tx_capture
    import pcs_tx_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tx_en,
    input  logic       tx_er,
    input  sym_t       txd,
    input  logic       scramble_en,
    input  logic       symbol_mode,
    output mii_beat_t  beat
);

    mii_beat_t cap_d, cap_q;

    always_comb begin
        cap_d     = cap_q;
        cap_d.en  = tx_en;
        cap_d.er  = tx_er;
        cap_d.d   = txd;
        cap_d.scr = scramble_en;
        cap_d.raw = symbol_mode;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cap_q <= '0;
        else        cap_q <= cap_d;
    end

    assign beat = cap_q;

endmodule

// File: rtl/pcs_tx_framer.sv
module pcs_tx_framer
    import pcs_tx_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  mii_beat_t  beat,
    output sym_t       code
);

    typedef struct packed {
        fr_state_e st;
    } fr_t;

    fr_t  fr_d, fr_q;
    sym_t code_d;

    always_comb begin
        fr_d   = fr_q;
        code_d = SYM_IDLE;
        unique case (fr_q.st)
            FR_IDLE: begin
                if (beat.en) begin
                    code_d  = SYM_J;
                    fr_d.st = FR_K;
                end
            end
            FR_K: begin
                if (beat.en) begin
                    code_d  = SYM_K;
                    fr_d.st = FR_DATA;
                end else begin
                    code_d  = SYM_T;
                    fr_d.st = FR_R;
                end
            end
            FR_DATA: begin
                if (!beat.en) begin
                    code_d  = SYM_T;
                    fr_d.st = FR_R;
                end else if (beat.er) begin
                    code_d  = SYM_H;
                end else begin
                    code_d  = enc_4b5b(beat.d[NIB_W-1:0]);
                end
            end
            default: begin
                code_d  = SYM_R;
                fr_d.st = FR_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) fr_q.st <= FR_IDLE;
        else        fr_q    <= fr_d;
    end

    assign code = code_d;

endmodule

// File: rtl/pcs_tx_scrambler.sv
module pcs_tx_scrambler #(
    parameter int W     = 11,
    parameter int TAP   = 9,
    parameter int SEED  = 11'h7FF,
    parameter int STEPS = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic [STEPS-1:0] key,
    output logic [W-1:0]     state
);

    localparam logic [W-1:0] SEED_W    = W'(SEED);
    localparam logic [W-1:0] SEED_SAFE = (SEED_W == '0) ? W'(1) : SEED_W;

    typedef struct packed {
        logic [W-1:0] lfsr;
    } scr_t;

    scr_t             scr_d, scr_q;
    logic [STEPS-1:0] key_d;

    always_comb begin
        logic [W-1:0] s;
        logic         fb;
        s     = scr_q.lfsr;
        key_d = '0;
        for (int k = 0; k < STEPS; k++) begin
            fb                  = s[W-1] ^ s[TAP-1];
            key_d[STEPS-1-k]    = fb;
            s                   = {s[W-2:0], fb};
        end
        scr_d.lfsr = s;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) scr_q.lfsr <= SEED_SAFE;
        else        scr_q      <= scr_d;
    end

    assign key   = key_d;
    assign state = scr_q.lfsr;

endmodule

// File: rtl/pcs_tx_encoder.sv
module pcs_tx_encoder
    import pcs_tx_pkg::*;
#(
    parameter int LFSR_W    = 11,
    parameter int LFSR_TAP  = 9,
    parameter int LFSR_SEED = 11'h7FF
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tx_en,
    input  logic       tx_er,
    input  logic [4:0] txd,
    input  logic       scramble_en,
    input  logic       symbol_mode,
    output logic [4:0] sym_out
);

    typedef struct packed {
        sym_t sym;
    } out_t;

    mii_beat_t         beat;
    sym_t              code;
    logic [SYM_W-1:0]  key;
    logic [LFSR_W-1:0] lfsr_state;
    out_t              out_d, out_q;

    pcs_tx_capture u_capture (
        .clk         (clk),
        .rst_n       (rst_n),
        .tx_en       (tx_en),
        .tx_er       (tx_er),
        .txd         (txd),
        .scramble_en (scramble_en),
        .symbol_mode (symbol_mode),
        .beat        (beat)
    );

    pcs_tx_framer u_framer (
        .clk   (clk),
        .rst_n (rst_n),
        .beat  (beat),
        .code  (code)
    );

    pcs_tx_scrambler #(
        .W     (LFSR_W),
        .TAP   (LFSR_TAP),
        .SEED  (LFSR_SEED),
        .STEPS (SYM_W)
    ) u_scrambler (
        .clk   (clk),
        .rst_n (rst_n),
        .key   (key),
        .state (lfsr_state)
    );

    always_comb begin
        out_d = out_q;
        if (beat.raw)      out_d.sym = beat.d;
        else if (beat.scr) out_d.sym = code ^ key;
        else               out_d.sym = code;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) out_q.sym <= SYM_IDLE;
        else        out_q     <= out_d;
    end

    assign sym_out = out_q.sym;

endmodule

// File: rtl/pcs_tx_encoder_chk.sv
module pcs_tx_encoder_chk #(
    parameter int LFSR_W = 11
) (
    input logic              clk,
    input logic              rst_n,
    input logic              tx_en,
    input logic              tx_er,
    input logic [4:0]        txd,
    input logic              scramble_en,
    input logic              symbol_mode,
    input logic [4:0]        sym_out,
    input logic [LFSR_W-1:0] lfsr_state
);

    logic [2:0] cyc_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)             cyc_q <= '0;
        else if (cyc_q != 3'd7) cyc_q <= cyc_q + 3'd1;
    end

    // R10: scrambler never locks up at zero
    assert_lfsr_live_R10: assert property (@(posedge clk) disable iff (!rst_n)
        lfsr_state != '0);

    // R9 / R2: raw bypass, two-clock latency
    assert_bypass_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_q >= 3'd2 && $past(symbol_mode, 2)) |-> (sym_out == $past(txd, 2)));

    // R3: unscrambled idle fill after three quiet samples
    assert_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_q >= 3'd4 && !$past(symbol_mode, 2) && !$past(scramble_en, 2) &&
         !$past(tx_en, 2) && !$past(tx_en, 3) && !$past(tx_en, 4))
        |-> (sym_out == 5'b11111));

    // R4: J opens a frame after quiet samples
    assert_ssd_start_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_q >= 3'd4 && !$past(symbol_mode, 2) && !$past(scramble_en, 2) &&
         $past(tx_en, 2) && !$past(tx_en, 3) && !$past(tx_en, 4))
        |-> (sym_out == 5'b11000));

    // R6: T follows the fall of a running frame
    assert_end_t_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_q >= 3'd5 && !$past(symbol_mode, 2) && !$past(scramble_en, 2) &&
         !$past(tx_en, 2) && $past(tx_en, 3) && $past(tx_en, 4) && $past(tx_en, 5))
        |-> (sym_out == 5'b01101));

    // R7: error nibble inside a running frame becomes H
    assert_halt_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_q >= 3'd5 && !$past(symbol_mode, 2) && !$past(scramble_en, 2) &&
         $past(tx_en, 2) && $past(tx_er, 2) && $past(tx_en, 3) &&
         $past(tx_en, 4) && $past(tx_en, 5))
        |-> (sym_out == 5'b00100));

endmodule

bind pcs_tx_encoder pcs_tx_encoder_chk #(.LFSR_W(LFSR_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .tx_en       (tx_en),
    .tx_er       (tx_er),
    .txd         (txd),
    .scramble_en (scramble_en),
    .symbol_mode (symbol_mode),
    .sym_out     (sym_out),
    .lfsr_state  (lfsr_state)
);

// File: tb/tb_pcs_tx_encoder.sv
module tb_pcs_tx_encoder;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tx_en = 1'b0;
    logic       tx_er = 1'b0;
    logic [4:0] txd = 5'd0;
    logic       scramble_en = 1'b0;
    logic       symbol_mode = 1'b0;
    logic [4:0] sym_out;

    int checks = 0;
    int fails  = 0;
    bit check_on = 1'b0;
    bit after_bypass = 1'b0;

    always #5 clk = ~clk;

    pcs_tx_encoder dut (
        .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .tx_er(tx_er), .txd(txd),
        .scramble_en(scramble_en), .symbol_mode(symbol_mode), .sym_out(sym_out)
    );

    function automatic logic [4:0] tbl(input logic [3:0] n);
        logic [4:0] v [16] = '{5'h1E, 5'h09, 5'h14, 5'h15, 5'h0A, 5'h0B, 5'h0E, 5'h0F,
                              5'h12, 5'h13, 5'h16, 5'h17, 5'h1A, 5'h1B, 5'h1C, 5'h1D};
        return v[n];
    endfunction

    // Behavioural reference: previous sample, frame counters, scrambler integer
    int         m_lfsr;
    int         m_cnt;
    int         m_tail;
    logic [8:0] m_prev;      // {en, er, raw, scr, d[4:0]}
    logic [4:0] exp_sym;
    string      exp_tag;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_lfsr = 11'h7FF; m_cnt = 0; m_tail = 0; m_prev = '0;
            exp_sym = 5'h1F; exp_tag = "R1";
        end else begin
            logic [4:0] key;
            logic [4:0] e;
            string      t;
            for (int k = 0; k < 5; k++) begin
                int fb;
                fb = ((m_lfsr >> 10) ^ (m_lfsr >> 8)) & 1;
                key[4-k] = fb[0];
                m_lfsr = ((m_lfsr << 1) | fb) & 11'h7FF;
            end
            if (m_tail == 1) begin
                e = 5'b00111; t = "R6"; m_tail = 0; m_cnt = 0;
            end else if (m_prev[8]) begin
                m_cnt++;
                if (m_cnt == 1)      begin e = 5'b11000; t = "R4"; end
                else if (m_cnt == 2) begin e = 5'b10001; t = "R4"; end
                else if (m_prev[7])  begin e = 5'b00100; t = "R7"; end
                else                 begin e = tbl(m_prev[3:0]); t = "R5"; end
            end else if (m_cnt > 0) begin
                e = 5'b01101; t = "R6"; m_tail = 1; m_cnt = 0;
            end else begin
                e = 5'b11111; t = "R3";
            end
            if (m_prev[6]) begin
                e = m_prev[4:0]; t = "R9";
            end else if (m_prev[5]) begin
                e = e ^ key; t = after_bypass ? "R10" : "R8";
            end
            exp_sym = e; exp_tag = t;
            m_prev = {tx_en, tx_er, symbol_mode, scramble_en, txd};
        end
    end

    task automatic check(input string tag, input logic [4:0] act, input logic [4:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: sym_out=%b expected %b at %0t", tag, act, exp, $time);
        end
    endtask

    // Per-clock comparison; every one also confirms the R2 two-clock alignment
    always @(negedge clk) if (check_on) check(exp_tag, sym_out, exp_sym);

    task automatic beat(input logic en, input logic er, input logic [4:0] d);
        @(negedge clk);
        tx_en = en; tx_er = er; txd = d;
    endtask

    task automatic frame(input int n, input int first, input int er_at);
        for (int i = 0; i < n; i++)
            beat(1'b1, i == er_at, 5'((first + i) & 5'h1F));
        beat(1'b0, 1'b0, 5'd0);
    endtask

    task automatic quiet(input int n);
        for (int i = 0; i < n; i++) beat(1'b0, 1'b0, 5'd0);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        fails++;
        $display("FAIL R2: watchdog expired, actual=running expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1", sym_out, 5'b11111);
        rst_n = 1'b1;
        check_on = 1'b1;
        // fiber mode: idle, then explicit R2 latency probe
        quiet(4);
        @(negedge clk);
        tx_en = 1'b1; txd = 5'h3;
        @(negedge clk);
        checks++; if (sym_out !== 5'b11111) begin fails++; $display("FAIL R2: sym_out=%b expected 11111", sym_out); end
        tx_en = 1'b1; txd = 5'h4;
        @(negedge clk);
        checks++; if (sym_out !== 5'b11000) begin fails++; $display("FAIL R2: sym_out=%b expected 11000", sym_out); end
        for (int i = 0; i < 16; i++) beat(1'b1, 1'b0, 5'(i) | 5'h10); // R5 all nibbles, bit 4 set
        quiet(4);
        frame(6, 2, 3);     // R7 H on a data nibble
        quiet(3);
        frame(5, 9, 0);     // R7 error on J position ignored
        quiet(3);
        frame(5, 1, 1);     // R7 error on K position ignored
        quiet(3);
        beat(1'b0, 1'b1, 5'h7); beat(1'b0, 1'b1, 5'h2); // R7 error outside a frame
        quiet(3);
        frame(1, 4, -1);    // R6 T lands in the K slot
        quiet(3);
        frame(2, 5, -1);    // R6 T right after K
        quiet(3);
        frame(3, 6, -1);
        beat(1'b1, 1'b0, 5'h8); // R6 new start during R is swallowed
        frame(4, 10, -1);
        quiet(4);
        // copper mode with scrambling (R8)
        scramble_en = 1'b1;
        quiet(4);
        frame(10, 0, 5);
        quiet(3);
        frame(8, 7, -1);
        quiet(3);
        // symbol mode with scramble still requested (R9)
        symbol_mode = 1'b1;
        for (int i = 0; i < 32; i++) beat(i[1], i[2], 5'(i));
        beat(1'b0, 1'b0, 5'd0);
        symbol_mode = 1'b0;
        tx_en = 1'b0;
        after_bypass = 1'b1;
        // key continues after bypass (R10)
        quiet(4);
        frame(12, 3, 7);
        quiet(4);
        scramble_en = 1'b0;
        after_bypass = 1'b0;
        quiet(3);
        frame(4, 12, -1);
        quiet(4);
        check_on = 1'b0;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule